// File: doc/BRIEF.md
# Shifted-Operand Subtract Flag Unit

This unit is the execute-stage datapath for the flag-setting subtract whose second operand comes from a shifted register, on a machine with 64-bit registers. Each cycle it may take one 32-bit instruction word and the two source register values, which the register file has already read. It checks that the word is this instruction form and shifts the second value by an encoded kind and amount. It then subtracts the shifted value from the first value and registers the difference, the destination index, a single write enable that covers both the register write and the flag write, and the four condition flags.

Bit 31 of the word picks the data size for each instruction. At the 32-bit size only the low halves of the operands take part, the shift works within 32 bits, and the result is zero-extended. The subtraction is an add of the inverted operand with a carry-in of one, so the carry flag means "no borrow". At the narrow size, an encoding whose amount is 32 or more raises an undefined-instruction output in place of a write. Any other encoding, such as the extended-register or immediate forms, leaves the unit's state unchanged.

Top module: `subflag_unit`

## Requirements
- R1: A valid word is accepted only when bits 30:24 equal 1101011 and bit 21 is 0. Any other word gives `wr_en_o`=0 and `undef_o`=0, and leaves `res_o`, `rd_o` and `flags_o` at their previous values.
- R2: For an accepted word, `rd_o` equals bits 4:0. The shift amount is taken from bits 15:10, the shift kind from bits 23:22, and the size from bit 31 (1 = 64-bit, 0 = 32-bit).
- R3: The shift kind encodings are 00 = logical left, 01 = logical right, 10 = arithmetic right and 11 = rotate right. Each is applied to the second operand at the active size.
- R4: An amount of 0 passes the second operand through unchanged for all four kinds. Rotate right wraps bits around modulo the active size.
- R5: `res_o` equals the first operand minus the shifted operand, modulo 2 to the power of the size. At 32-bit size it uses the low 32 bits of both operands, and bits 63:32 of `res_o` are 0.
- R6: `flags_o` bit 3 is N and bit 2 is Z. N is the top bit of the result at the active size. Z is 1 exactly when the result at the active size is all zeros.
- R7: `flags_o` bit 1 (C) is 1 exactly when no borrow occurs at the active size, which is when the unsigned first operand is greater than or equal to the shifted operand.
- R8: `flags_o` bit 0 (V) is 1 exactly when the signed difference at the active size falls outside the signed range of that size.
- R9: An accepted-form word at 32-bit size with amount bit 5 set gives `undef_o`=1 and `wr_en_o`=0, and leaves `res_o`, `rd_o` and `flags_o` unchanged.
- R10: Outputs are registered: the results of an input appear after one rising edge, with `out_valid_o` equal to the previous `in_valid_i`. While `in_valid_i`=0 nothing is written. A reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| opnd_a_i | input | 64 | First source register value |
| opnd_b_i | input | 64 | Second source register value, the one that is shifted |
| out_valid_o | output | 1 | Registered copy of the input valid |
| wr_en_o | output | 1 | Write of the destination register and of the flags |
| undef_o | output | 1 | Illegal shift amount at 32-bit size |
| rd_o | output | 5 | Destination register index |
| res_o | output | 64 | Difference, zero-extended at 32-bit size |
| flags_o | output | 4 | N, Z, C, V in bits 3 to 0 |

## Verification
The bench sweeps every shift kind against every amount from 0 to 63 at both sizes, over operand pairs chosen to separate the flags. Equal operands give Z with C set. A smaller minuend gives a borrow. The most negative value minus a positive value, and the most positive value minus minus one, give signed overflow. Pairs whose upper halves are non-zero must not affect narrow results. Amounts 32 to 63 at the narrow size tell the undefined path apart from a legal write. Single-bit corruptions of the opcode and of bit 21 tell accepted words apart from rejected ones, and show that rejected words leave the held outputs alone.

// File: rtl/sfu_pkg.sv
// Shared constants and types for the shifted-operand subtract flag unit.
// Assumes the fixed 32-bit instruction layout; data widths are module parameters.
package sfu_pkg;
    localparam int INSTR_W  = 32;
    localparam int REG_W    = 5;
    localparam int FIELD_AW = 6;
    localparam logic [6:0] OPC_SUB_FLAGS = 7'b1101011;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic                hit;
        logic                illegal;
        logic                wide;
        shift_kind_e         kind;
        logic [FIELD_AW-1:0] amt;
        logic [REG_W-1:0]    rd;
    } dec_t;
endpackage

// File: rtl/sfu_decode.sv
// Instruction decoder for the shifted-register subtract form.
// Raises hit for a legal accepted word and illegal for a narrow word whose
// amount is out of range. The source index fields are not needed here.
module sfu_decode
    import sfu_pkg::*;
(
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic form_match;
    logic amt_too_big;
    logic unused_fields;

    assign unused_fields = ^{instr_i[20:16], instr_i[9:5]};

    // Match the fixed opcode bits and the cleared form-select bit.
    always_comb begin : form_check
        form_match  = valid_i && (instr_i[30:24] == OPC_SUB_FLAGS) && !instr_i[21];
        amt_too_big = !instr_i[31] && instr_i[15];
    end

    // Pack the fields that the datapath consumes.
    always_comb begin : field_pack
        dec_o.wide    = instr_i[31];
        dec_o.kind    = shift_kind_e'(instr_i[23:22]);
        dec_o.amt     = instr_i[15:10];
        dec_o.rd      = instr_i[4:0];
        dec_o.illegal = form_match && amt_too_big;
        dec_o.hit     = form_match && !amt_too_big;
    end
endmodule

// File: rtl/sfu_shift.sv
// Operand shifter with one lane for the full width and one for the narrow width.
// Each lane applies the encoded kind at its own width; the narrow lane ignores
// the upper operand bits and amount bit 5 and zero-extends its output.
module sfu_shift
    import sfu_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int AMT_W    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  shift_kind_e       kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] shifted_o
);
    logic [DATA_W-1:0] lane_out [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? DATA_W : NARROW_W;
        localparam int LA = $clog2(LW);
        logic [LW-1:0] src;
        logic [LW-1:0] res;
        logic [LA-1:0] sa;
        logic [LA:0]   back;

        assign src  = opnd_i[LW-1:0];
        assign sa   = amt_i[LA-1:0];
        assign back = (LA+1)'(LW) - {1'b0, sa};

        // Select the shift kind at this lane's width.
        always_comb begin : kind_sel
            res = src;
            case (kind_i)
                SH_LSL: res = src << sa;
                SH_LSR: res = src >> sa;
                SH_ASR: res = LW'($signed(src) >>> sa);
                SH_ROR: res = (src >> sa) | (src << back);
                default: res = src;
            endcase
        end

        if (LW == DATA_W) begin : g_full
            assign lane_out[g] = res;
        end else begin : g_ext
            assign lane_out[g] = {{(DATA_W-LW){1'b0}}, res};
        end
    end

    assign shifted_o = wide_i ? lane_out[0] : lane_out[1];
endmodule

// File: rtl/sfu_addflag.sv
// Subtract as an add of the inverted operand with carry-in one, per width lane.
// Flags are taken at the lane's own top bit, so the narrow size yields its
// own carry and overflow. Output flags are packed N, Z, C, V from bit 3 down.
module sfu_addflag #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] diff_o,
    output logic [3:0]        nzcv_o
);
    logic [DATA_W-1:0] lane_diff [2];
    logic [3:0]        lane_nzcv [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? DATA_W : NARROW_W;
        logic [LW:0]   sum;
        logic [LW-1:0] s;
        logic          a_top;
        logic          b_top;

        assign a_top = a_i[LW-1];
        assign b_top = b_i[LW-1];

        // One adder: minuend plus inverted subtrahend plus one.
        always_comb begin : add_inv
            sum = {1'b0, a_i[LW-1:0]} + {1'b0, ~b_i[LW-1:0]} + (LW+1)'(1);
            s   = sum[LW-1:0];
        end

        // Derive the four flags at this width.
        always_comb begin : flag_gen
            lane_nzcv[g][3] = s[LW-1];
            lane_nzcv[g][2] = ~|s;
            lane_nzcv[g][1] = sum[LW];
            lane_nzcv[g][0] = (a_top ^ b_top) & (s[LW-1] ^ a_top);
        end

        if (LW == DATA_W) begin : g_full
            assign lane_diff[g] = s;
        end else begin : g_ext
            assign lane_diff[g] = {{(DATA_W-LW){1'b0}}, s};
        end
    end

    assign diff_o = wide_i ? lane_diff[0] : lane_diff[1];
    assign nzcv_o = wide_i ? lane_nzcv[0] : lane_nzcv[1];
endmodule

// File: rtl/subflag_unit.sv
// Top of the shifted-operand subtract flag unit.
// Decodes the word, shifts the second operand, subtracts, and registers the
// outputs with a latency of one cycle. Assumes the operands are valid in the
// same cycle as the word. Result, index and flags hold unless a write occurs.
module subflag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  opnd_a_i,
    input  logic [DATA_W-1:0]  opnd_b_i,
    output logic               out_valid_o,
    output logic               wr_en_o,
    output logic               undef_o,
    output logic [REG_W-1:0]   rd_o,
    output logic [DATA_W-1:0]  res_o,
    output logic [3:0]         flags_o
);
    localparam int AMT_W = $clog2(DATA_W);

    dec_t              dec;
    logic [DATA_W-1:0] b_shifted;
    logic [DATA_W-1:0] diff;
    logic [3:0]        nzcv;
    logic [AMT_W-1:0]  amt;

    assign amt = AMT_W'(dec.amt);

    sfu_decode u_dec (
        .valid_i (in_valid_i),
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    sfu_shift #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .AMT_W(AMT_W)) u_shift (
        .opnd_i    (opnd_b_i),
        .kind_i    (dec.kind),
        .amt_i     (amt),
        .wide_i    (dec.wide),
        .shifted_o (b_shifted)
    );

    sfu_addflag #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_add (
        .a_i    (opnd_a_i),
        .b_i    (b_shifted),
        .wide_i (dec.wide),
        .diff_o (diff),
        .nzcv_o (nzcv)
    );

    // Register the control outputs every cycle.
    always_ff @(posedge clk) begin : ctrl_reg
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            wr_en_o     <= 1'b0;
            undef_o     <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            wr_en_o     <= dec.hit;
            undef_o     <= dec.illegal;
        end
    end

    // Capture the data outputs only for an accepted, legal word.
    always_ff @(posedge clk) begin : data_reg
        if (!rst_n) begin
            rd_o    <= '0;
            res_o   <= '0;
            flags_o <= '0;
        end else if (dec.hit) begin
            rd_o    <= dec.rd;
            res_o   <= diff;
            flags_o <= nzcv;
        end
    end
endmodule

// File: rtl/sfu_chk.sv
// Property checker for subflag_unit, attached by bind. Observes ports only.
module sfu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid_i,
    input logic [31:0] instr_i,
    input logic        out_valid_o,
    input logic        wr_en_o,
    input logic        undef_o,
    input logic [4:0]  rd_o,
    input logic [63:0] res_o,
    input logic [3:0]  flags_o
);
    assert_accept_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(instr_i[30:24]) == 7'b1101011) && !$past(instr_i[21]));

    assert_hold_on_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |-> $stable(res_o) && $stable(flags_o) && $stable(rd_o));

    assert_dest_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> rd_o == $past(instr_i[4:0]));

    assert_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !$past(instr_i[31])) |-> res_o[63:32] == 32'd0);

    assert_neg_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> flags_o[3] == ($past(instr_i[31]) ? res_o[63] : res_o[31]));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> flags_o[2] == (res_o == 64'd0));

    assert_undef_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> !wr_en_o && !$past(instr_i[31]) && $past(instr_i[15]));

    assert_valid_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o || undef_o || out_valid_o) |-> $past(in_valid_i));
endmodule

bind subflag_unit sfu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .instr_i     (instr_i),
    .out_valid_o (out_valid_o),
    .wr_en_o     (wr_en_o),
    .undef_o     (undef_o),
    .rd_o        (rd_o),
    .res_o       (res_o),
    .flags_o     (flags_o)
);

// File: tb/sim_subflag_unit.sv
module sim_subflag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vin = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        ovld, wr, und;
    logic [4:0]  rd;
    logic [63:0] res;
    logic [3:0]  flg;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [63:0] prev_res = '0;
    logic [3:0]  prev_flg = '0;
    logic [4:0]  prev_rd = '0;
    logic [63:0] pa [6];
    logic [63:0] pb [6];

    always #10 clk = ~clk;

    subflag_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(vin), .instr_i(instr),
        .opnd_a_i(opa), .opnd_b_i(opb), .out_valid_o(ovld), .wr_en_o(wr),
        .undef_o(und), .rd_o(rd), .res_o(res), .flags_o(flg)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] mk(input logic wide, input logic [1:0] k,
                                       input logic [5:0] amt, input logic [4:0] rdi);
        return {wide, 7'b1101011, k, 1'b0, 5'd7, amt, 5'd3, rdi};
    endfunction

    function automatic logic [63:0] ref_shift(input logic [63:0] x, input int k,
                                              input int amt, input int w);
        logic [63:0] o = '0;
        for (int i = 0; i < w; i++) begin
            case (k)
                0: if (i >= amt) o[i] = x[i-amt];
                1: if (i + amt < w) o[i] = x[i+amt];
                2: o[i] = (i + amt < w) ? x[i+amt] : x[w-1];
                default: o[i] = x[(i+amt) % w];
            endcase
        end
        return o;
    endfunction

    task automatic ref_sub(input logic [63:0] a, input logic [63:0] b, input int w,
                           output logic [63:0] r, output logic [3:0] f);
        logic [63:0] mask, aw, bw;
        logic signed [67:0] sa, sb, d, lim;
        mask = (w == 64) ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF;
        aw = a & mask;
        bw = b & mask;
        r  = (aw - bw) & mask;
        sa = {4'b0, aw};
        sb = {4'b0, bw};
        if (aw[w-1]) sa = sa - (68'sd1 <<< w);
        if (bw[w-1]) sb = sb - (68'sd1 <<< w);
        d   = sa - sb;
        lim = 68'sd1 <<< (w - 1);
        f[3] = r[w-1];
        f[2] = (r == 64'd0);
        f[1] = (aw >= bw);
        f[0] = (d >= lim) || (d < -lim);
    endtask

    task automatic apply(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b);
        instr = ins; opa = a; opb = b; vin = 1'b1;
        @(negedge clk);
        vin = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        pa[0] = 64'd0;                  pb[0] = 64'd0;
        pa[1] = 64'd5;                  pb[1] = 64'd5;
        pa[2] = 64'd1;                  pb[2] = 64'd2;
        pa[3] = 64'h8000_0000_0000_0000; pb[3] = 64'd1;
        pa[4] = 64'h7FFF_FFFF_FFFF_FFFF; pb[4] = {64{1'b1}};
        pa[5] = 64'hDEAD_BEEF_8000_0000; pb[5] = 64'h1234_5678_0000_0001;

        repeat (3) @(negedge clk);
        chk("R10 reset out_valid", {63'd0, ovld}, 64'd0);
        chk("R10 reset write", {63'd0, wr}, 64'd0);
        chk("R10 reset undef", {63'd0, und}, 64'd0);
        chk("R10 reset result", res, 64'd0);
        chk("R10 reset flags", {60'd0, flg}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int ws = 0; ws < 2; ws++) begin
            for (int k = 0; k < 4; k++) begin
                for (int amt = 0; amt < 64; amt++) begin
                    for (int p = 0; p < 6; p++) begin
                        int w;
                        logic [4:0]  rdi;
                        logic [63:0] bs, er;
                        logic [3:0]  ef;
                        w   = ws ? 64 : 32;
                        rdi = 5'(amt + p + k);
                        apply(mk(ws[0], 2'(k), 6'(amt), rdi), pa[p], pb[p]);
                        chk("R10 out_valid", {63'd0, ovld}, 64'd1);
                        if (ws == 0 && amt >= 32) begin
                            chk("R9 undef raised", {63'd0, und}, 64'd1);
                            chk("R9 write blocked", {63'd0, wr}, 64'd0);
                            chk("R9 result held", res, prev_res);
                            chk("R9 flags held", {60'd0, flg}, {60'd0, prev_flg});
                        end else begin
                            bs = ref_shift(pb[p], k, amt, w);
                            ref_sub(pa[p], bs, w, er, ef);
                            chk("R1 write", {63'd0, wr}, 64'd1);
                            chk("R9 undef clear", {63'd0, und}, 64'd0);
                            chk("R2 dest index", {59'd0, rd}, {59'd0, rdi});
                            if (amt == 0) chk("R4 zero amount result", res, er);
                            else          chk("R3 R5 result", res, er);
                            chk("R6 N Z", {62'd0, flg[3:2]}, {62'd0, ef[3:2]});
                            chk("R7 carry", {63'd0, flg[1]}, {63'd0, ef[1]});
                            chk("R8 overflow", {63'd0, flg[0]}, {63'd0, ef[0]});
                            prev_res = er; prev_flg = ef; prev_rd = rdi;
                        end
                    end
                end
            end
        end

        // Rejected encodings: one corrupted opcode or form bit each.
        for (int bi = 21; bi < 31; bi++) begin
            if (bi == 22 || bi == 23) continue;
            apply(mk(1'b1, 2'd0, 6'd1, 5'd9) ^ (32'd1 << bi), 64'd100, 64'd3);
            chk("R1 rejected no write", {63'd0, wr}, 64'd0);
            chk("R1 rejected no undef", {63'd0, und}, 64'd0);
            chk("R1 rejected result held", res, prev_res);
            chk("R1 rejected flags held", {60'd0, flg}, {60'd0, prev_flg});
            chk("R1 rejected index held", {59'd0, rd}, {59'd0, prev_rd});
        end

        // A legal word without valid must not write.
        instr = mk(1'b1, 2'd0, 6'd0, 5'd1); opa = 64'd9; opb = 64'd4; vin = 1'b0;
        @(negedge clk);
        chk("R10 idle out_valid", {63'd0, ovld}, 64'd0);
        chk("R10 idle no write", {63'd0, wr}, 64'd0);
        chk("R10 idle result held", res, prev_res);

        finish_up();
    end
endmodule